// File: doc/BRIEF.md
# Dual-Issue In-Order Scoreboard

This block controls issue and retirement for a two-wide core that issues and retires strictly in program order. In each cycle the decoder presents up to two instructions. The older one is in slot 0 and the younger one is in slot 1. Each instruction carries two source registers, a destination register and a functional-unit index. The block keeps a reservation record for every architectural register: a count of pending readers and a flag for a pending writer. It issues a slot only when that slot has no register hazard and its unit is free. Otherwise it stalls, and fetch must hold the un-issued instructions.

Every issued instruction takes an entry in an eight-deep circular queue and receives the entry index as its tag. Functional units report completion by tag, in any order. Finished entries leave the queue from the head only, at most two per cycle. Register reservations are released at retirement, not at completion. A stalled instruction is therefore evaluated again in the cycle after the retirement that frees it.

Top module: `scb_dual_issue`

## Requirements
- R1: Two valid, hazard-free slots on different free units issue together (`issue` = 2'b11). Slot 0 takes tag `issue_tag0`, which equals the number of instructions issued since reset modulo 8. Slot 1 takes the next tag.
- R2: A slot does not issue while either of its source registers has a pending writer (read after write).
- R3: A slot does not issue while its destination has at least one pending reader (write after read).
- R4: A slot does not issue while its destination already has a pending writer (write after write). After issue, that register shows a pending writer.
- R5: A slot issues only if `unit_free` bit number `unit` is 1.
- R6: Any number of pending instructions may read the same register. Sixteen simultaneous source references to one register (eight entries with both sources equal) do not stop a non-conflicting issue.
- R7: Slot 1 never issues unless slot 0 issues in the same cycle. Slot 1 also stalls if it reads slot 0's destination, writes one of slot 0's sources or its destination, or names the same unit.
- R8: `fetch_stall` is 1 exactly when some valid slot did not issue in that cycle.
- R9: With 8 entries pending, nothing issues. With 7 pending, only slot 0 may issue. Entries retiring in the same cycle do not make room until the next cycle.
- R10: A completion pulse on `cmp_valid[k]` marks the entry on `cmp_tagk` done at the clock edge. `retire_cnt` (0, 1 or 2) then counts the consecutive done entries at the head. Done entries behind an unfinished older entry wait.
- R11: Retiring an instruction removes its reader and writer reservations at the same edge, so a stalled dependent issues in the following cycle. No reader count ever goes below zero.
- R12: Reset empties the queue and clears every reservation. Afterwards `issue`, `retire_cnt` and `fetch_stall` are 0 with idle inputs, and the first tag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s0_valid | input | 1 | Older slot holds an instruction |
| s0_src_a | input | 4 | Older slot first source register |
| s0_src_b | input | 4 | Older slot second source register |
| s0_dst | input | 4 | Older slot destination register |
| s0_unit | input | 2 | Older slot functional-unit index |
| s1_valid | input | 1 | Younger slot holds an instruction |
| s1_src_a | input | 4 | Younger slot first source register |
| s1_src_b | input | 4 | Younger slot second source register |
| s1_dst | input | 4 | Younger slot destination register |
| s1_unit | input | 2 | Younger slot functional-unit index |
| unit_free | input | 4 | One bit per functional unit, 1 = can accept |
| cmp_valid | input | 2 | Completion pulses, one per report port |
| cmp_tag0 | input | 3 | Tag completed on port 0 |
| cmp_tag1 | input | 3 | Tag completed on port 1 |
| issue | output | 2 | Per-slot issue grant this cycle |
| issue_tag0 | output | 3 | Tag given to slot 0 |
| issue_tag1 | output | 3 | Tag given to slot 1 |
| fetch_stall | output | 1 | Back-pressure to fetch |
| retire_cnt | output | 2 | Instructions retired at the coming edge |

## Verification
The hardest situation to reach is an instruction that has already finished but is held behind an unfinished older one. Its reservation must stay in force until the older instruction also completes. The stimulus completes a younger tag first, keeps a dependent stalled on its register across several cycles, and then completes the older tag. It checks that both retire together and that the dependent issues exactly one cycle later. The queue-full boundary is reached by issuing eight non-conflicting instructions that all read the same register. A completion then arrives while the queue is still full, which shows that a same-cycle retirement does not create room.

// File: rtl/scb_pkg.sv
package scb_pkg;
  localparam int unsigned NREG   = 16;
  localparam int unsigned QDEPTH = 8;   // power of two: pointers wrap by overflow
  localparam int unsigned NUNIT  = 4;

  localparam int unsigned RIDX_W = $clog2(NREG);
  localparam int unsigned QIDX_W = $clog2(QDEPTH);
  localparam int unsigned UIDX_W = $clog2(NUNIT);
  localparam int unsigned QCNT_W = $clog2(QDEPTH + 1);
  localparam int unsigned RCNT_W = $clog2(2 * QDEPTH + 1);

  typedef logic [RIDX_W-1:0] reg_t;
  typedef logic [UIDX_W-1:0] unit_t;
  typedef logic [QIDX_W-1:0] tag_t;

  typedef struct packed {
    logic  vld;
    reg_t  sa;
    reg_t  sb;
    reg_t  dst;
    unit_t unit;
  } slot_t;

  typedef struct packed {
    reg_t sa;
    reg_t sb;
    reg_t dst;
    logic done;
  } entry_t;

  // Slot is free of hazards against pending work and its unit can accept.
  function automatic logic slot_clear(slot_t s, logic [NREG-1:0] rd_busy,
                                      logic [NREG-1:0] wr_busy,
                                      logic [NUNIT-1:0] ufree);
    return !wr_busy[s.sa] && !wr_busy[s.sb] &&
           !rd_busy[s.dst] && !wr_busy[s.dst] && ufree[s.unit];
  endfunction

  // Younger slot conflicts with the older slot issuing in the same cycle.
  function automatic logic pair_clash(slot_t o, slot_t y);
    return (y.sa == o.dst) || (y.sb == o.dst) ||
           (y.dst == o.sa) || (y.dst == o.sb) ||
           (y.dst == o.dst) || (y.unit == o.unit);
  endfunction

  // Consecutive done entries at the head, at most two.
  function automatic logic [1:0] retire_sel(logic d0, logic d1,
                                            logic [QCNT_W-1:0] cnt);
    logic [1:0] m;
    m[0] = d0 && (cnt >= QCNT_W'(1));
    m[1] = m[0] && d1 && (cnt >= QCNT_W'(2));
    return m;
  endfunction
endpackage

// File: rtl/scb_hazard.sv
module scb_hazard
  import scb_pkg::*;
(
  input  slot_t             s0,
  input  slot_t             s1,
  input  logic [NREG-1:0]   rd_busy,
  input  logic [NREG-1:0]   wr_busy,
  input  logic [NUNIT-1:0]  ufree,
  input  logic [QCNT_W-1:0] q_count,
  output logic [1:0]        go,
  output logic [1:0]        blocked
);
  logic room_one, room_two;

  assign room_one = q_count < QCNT_W'(QDEPTH);
  assign room_two = q_count < QCNT_W'(QDEPTH - 1);

  always_comb begin
    go[0] = s0.vld && room_one && slot_clear(s0, rd_busy, wr_busy, ufree);
    go[1] = go[0] && s1.vld && room_two &&
            slot_clear(s1, rd_busy, wr_busy, ufree) && !pair_clash(s0, s1);
    blocked = {s1.vld && !go[1], s0.vld && !go[0]};
  end
endmodule

// File: rtl/scb_queue.sv
module scb_queue
  import scb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        go,
  input  slot_t             s0,
  input  slot_t             s1,
  input  logic [1:0]        cmp_vld,
  input  tag_t              cmp_t0,
  input  tag_t              cmp_t1,
  output tag_t              tag0,
  output tag_t              tag1,
  output logic [QCNT_W-1:0] count,
  output logic [1:0]        ret_mask,
  output entry_t            ret_e0,
  output entry_t            ret_e1
);
  entry_t q [QDEPTH];
  tag_t   head, tail, head_nx;
  logic [QCNT_W-1:0] n_push, n_pop;

  assign head_nx  = head + QIDX_W'(1);
  assign tag0     = tail;
  assign tag1     = tail + QIDX_W'(1);
  assign ret_e0   = q[head];
  assign ret_e1   = q[head_nx];
  assign ret_mask = retire_sel(q[head].done, q[head_nx].done, count);
  assign n_push   = QCNT_W'(go[0]) + QCNT_W'(go[1]);
  assign n_pop    = QCNT_W'(ret_mask[0]) + QCNT_W'(ret_mask[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
      for (int i = 0; i < QDEPTH; i++) q[i] <= '0;
    end else begin
      if (cmp_vld[0]) q[cmp_t0].done <= 1'b1;
      if (cmp_vld[1]) q[cmp_t1].done <= 1'b1;
      if (go[0]) q[tag0] <= '{sa: s0.sa, sb: s0.sb, dst: s0.dst, done: 1'b0};
      if (go[1]) q[tag1] <= '{sa: s1.sa, sb: s1.sb, dst: s1.dst, done: 1'b0};
      head  <= head + QIDX_W'(n_pop);
      tail  <= tail + QIDX_W'(n_push);
      count <= count + n_push - n_pop;
    end
  end
endmodule

// File: rtl/scb_regtrack.sv
module scb_regtrack
  import scb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      go,
  input  slot_t           s0,
  input  slot_t           s1,
  input  logic [1:0]      ret_mask,
  input  entry_t          ret_e0,
  input  entry_t          ret_e1,
  output logic [NREG-1:0] rd_busy,
  output logic [NREG-1:0] wr_busy,
  output logic            rel_fault
);
  logic [NREG-1:0] fault;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    localparam reg_t ID = RIDX_W'(r);
    logic [RCNT_W-1:0] cnt, inc, dec;
    logic wr, set, clr;

    always_comb begin
      inc = RCNT_W'(go[0] && s0.sa == ID) + RCNT_W'(go[0] && s0.sb == ID) +
            RCNT_W'(go[1] && s1.sa == ID) + RCNT_W'(go[1] && s1.sb == ID);
      dec = RCNT_W'(ret_mask[0] && ret_e0.sa == ID) +
            RCNT_W'(ret_mask[0] && ret_e0.sb == ID) +
            RCNT_W'(ret_mask[1] && ret_e1.sa == ID) +
            RCNT_W'(ret_mask[1] && ret_e1.sb == ID);
      set = (go[0] && s0.dst == ID) || (go[1] && s1.dst == ID);
      clr = (ret_mask[0] && ret_e0.dst == ID) || (ret_mask[1] && ret_e1.dst == ID);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt <= '0;
        wr  <= 1'b0;
      end else begin
        cnt <= cnt + inc - dec;
        wr  <= (wr && !clr) || set;
      end
    end

    assign rd_busy[r] = |cnt;
    assign wr_busy[r] = wr;
    assign fault[r]   = (dec > cnt) || (clr && !wr);
  end

  assign rel_fault = |fault;
endmodule

// File: rtl/scb_dual_issue.sv
module scb_dual_issue
  import scb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s0_valid,
  input  logic [RIDX_W-1:0] s0_src_a,
  input  logic [RIDX_W-1:0] s0_src_b,
  input  logic [RIDX_W-1:0] s0_dst,
  input  logic [UIDX_W-1:0] s0_unit,
  input  logic              s1_valid,
  input  logic [RIDX_W-1:0] s1_src_a,
  input  logic [RIDX_W-1:0] s1_src_b,
  input  logic [RIDX_W-1:0] s1_dst,
  input  logic [UIDX_W-1:0] s1_unit,
  input  logic [NUNIT-1:0]  unit_free,
  input  logic [1:0]        cmp_valid,
  input  logic [QIDX_W-1:0] cmp_tag0,
  input  logic [QIDX_W-1:0] cmp_tag1,
  output logic [1:0]        issue,
  output logic [QIDX_W-1:0] issue_tag0,
  output logic [QIDX_W-1:0] issue_tag1,
  output logic              fetch_stall,
  output logic [1:0]        retire_cnt
);
  slot_t             sl0, sl1;
  logic [NREG-1:0]   rd_busy, wr_busy;
  logic [QCNT_W-1:0] q_count;
  logic [1:0]        ret_mask, blocked;
  entry_t            ret_e0, ret_e1;
  logic              rel_fault;

  assign sl0 = '{vld: s0_valid, sa: s0_src_a, sb: s0_src_b, dst: s0_dst, unit: s0_unit};
  assign sl1 = '{vld: s1_valid, sa: s1_src_a, sb: s1_src_b, dst: s1_dst, unit: s1_unit};

  scb_hazard u_haz (
    .s0(sl0), .s1(sl1), .rd_busy(rd_busy), .wr_busy(wr_busy),
    .ufree(unit_free), .q_count(q_count), .go(issue), .blocked(blocked)
  );

  scb_queue u_q (
    .clk(clk), .rst_n(rst_n), .go(issue), .s0(sl0), .s1(sl1),
    .cmp_vld(cmp_valid), .cmp_t0(cmp_tag0), .cmp_t1(cmp_tag1),
    .tag0(issue_tag0), .tag1(issue_tag1), .count(q_count),
    .ret_mask(ret_mask), .ret_e0(ret_e0), .ret_e1(ret_e1)
  );

  scb_regtrack u_rt (
    .clk(clk), .rst_n(rst_n), .go(issue), .s0(sl0), .s1(sl1),
    .ret_mask(ret_mask), .ret_e0(ret_e0), .ret_e1(ret_e1),
    .rd_busy(rd_busy), .wr_busy(wr_busy), .rel_fault(rel_fault)
  );

  assign fetch_stall = |blocked;
  assign retire_cnt  = {1'b0, ret_mask[0]} + {1'b0, ret_mask[1]};
endmodule

// File: rtl/scb_checker.sv
module scb_checker
  import scb_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        issue,
  input logic [RIDX_W-1:0] s0_src_a,
  input logic [RIDX_W-1:0] s0_src_b,
  input logic [RIDX_W-1:0] s0_dst,
  input logic [NREG-1:0]   wr_busy,
  input logic [QCNT_W-1:0] q_count,
  input logic [1:0]        ret_mask,
  input logic [1:0]        retire_cnt,
  input logic              rel_fault
);
  a_r7_in_order: assert property (@(posedge clk) disable iff (!rst_n)
    issue[1] |-> issue[0]);

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    issue[0] |-> q_count < QCNT_W'(QDEPTH));

  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= QCNT_W'(QDEPTH));

  a_r2_no_raw: assert property (@(posedge clk) disable iff (!rst_n)
    issue[0] |-> !wr_busy[s0_src_a] && !wr_busy[s0_src_b]);

  a_r4_no_waw: assert property (@(posedge clk) disable iff (!rst_n)
    issue[0] |-> !wr_busy[s0_dst]);

  a_r4_write_held: assert property (@(posedge clk) disable iff (!rst_n)
    issue[0] |=> wr_busy[$past(s0_dst)]);

  a_r10_head_first: assert property (@(posedge clk) disable iff (!rst_n)
    ret_mask[1] |-> ret_mask[0]);

  a_r10_retire_bound: assert property (@(posedge clk) disable iff (!rst_n)
    QCNT_W'(retire_cnt) <= q_count);

  a_r11_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    !rel_fault);
endmodule

bind scb_dual_issue scb_checker u_chk (
  .clk(clk), .rst_n(rst_n), .issue(issue), .s0_src_a(s0_src_a),
  .s0_src_b(s0_src_b), .s0_dst(s0_dst), .wr_busy(wr_busy),
  .q_count(q_count), .ret_mask(ret_mask), .retire_cnt(retire_cnt),
  .rel_fault(rel_fault)
);

// File: tb/sim_scb_dual_issue.sv
`timescale 1ns/1ps
module sim_scb_dual_issue;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s0_valid = 0, s1_valid = 0;
  logic [3:0] s0_src_a = 0, s0_src_b = 0, s0_dst = 0;
  logic [3:0] s1_src_a = 0, s1_src_b = 0, s1_dst = 0;
  logic [1:0] s0_unit = 0, s1_unit = 0;
  logic [3:0] unit_free = 4'hF;
  logic [1:0] cmp_valid = 0;
  logic [2:0] cmp_tag0 = 0, cmp_tag1 = 0;
  logic [1:0] issue, retire_cnt;
  logic [2:0] issue_tag0, issue_tag1;
  logic fetch_stall;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  int exp_tail = 0;

  always #2.5 clk = ~clk;

  scb_dual_issue u0 (.*);

  typedef struct packed {
    int v0, a0, b0, d0, u0;
    int v1, a1, b1, d1, u1;
    int uf, cv, c0, c1, ei, er, rq;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    '{1,2,3,1,0,  1,0,2,4,1,  15,0,0,0, 3,0, 1},  // R1 pair issues, tags 0,1
    '{1,4,6,5,0,  1,8,9,7,1,  15,0,0,0, 0,0, 2},  // R2 RAW on r4; R7 slot1 held
    '{1,8,9,2,0,  0,0,0,0,0,  15,0,0,0, 0,0, 3},  // R3 r2 has readers
    '{1,8,9,1,0,  0,0,0,0,0,  15,1,1,0, 0,0, 4},  // R4 r1 pending write; tag1 done
    '{1,8,9,10,2, 1,10,8,11,1,15,1,0,0, 1,0, 7},  // R7 intra RAW; R10 tag1 waits
    '{0,0,0,0,0,  0,0,0,0,0,  15,0,0,0, 0,2,10},  // R10 tags 0,1 retire together
    '{1,4,6,5,0,  1,12,13,2,3,15,0,0,0, 3,0,11},  // R11 released regs reusable
    '{1,12,12,14,1,0,0,0,0,0, 13,0,0,0, 0,0, 5},  // R5 unit 1 busy
    '{1,12,12,14,1,1,0,0,14,2,15,0,0,0, 1,0, 6},  // R6 shared read r12; R7 intra WAW
    '{0,0,0,0,0,  0,0,0,0,0,  15,3,2,3, 0,0,10},  // R10 complete 2,3
    '{0,0,0,0,0,  0,0,0,0,0,  15,3,4,5, 0,2,10},  // R10 retire 2,3
    '{0,0,0,0,0,  0,0,0,0,0,  15,0,0,0, 0,2,10},  // R10 retire 4,5
    '{1,0,0,1,0,  1,0,0,2,1,  15,0,0,0, 3,0, 6},  // R6 r0 shared
    '{1,0,0,3,0,  1,0,0,4,1,  15,0,0,0, 3,0, 6},
    '{1,0,0,5,0,  1,0,0,6,1,  15,0,0,0, 3,0, 6},
    '{1,0,0,7,0,  1,0,0,8,1,  15,0,0,0, 3,0, 6},  // R6 sixteen reads of r0
    '{1,0,0,9,0,  0,0,0,0,0,  15,1,6,0, 0,0, 9},  // R9 full
    '{1,0,0,9,0,  0,0,0,0,0,  15,0,0,0, 0,1, 9},  // R9 retiring entry not room yet
    '{1,0,0,9,0,  1,0,0,10,1, 15,0,0,0, 1,0, 9}   // R9 one free entry
  };

  task automatic chk(int rq, int act, int exp, string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    s0_valid = 0; s1_valid = 0; cmp_valid = 0; unit_free = 4'hF;
  endtask

  task automatic apply(vec_t v);
    s0_valid = v.v0[0]; s0_src_a = 4'(v.a0); s0_src_b = 4'(v.b0);
    s0_dst = 4'(v.d0); s0_unit = 2'(v.u0);
    s1_valid = v.v1[0]; s1_src_a = 4'(v.a1); s1_src_b = 4'(v.b1);
    s1_dst = 4'(v.d1); s1_unit = 2'(v.u1);
    unit_free = 4'(v.uf); cmp_valid = 2'(v.cv);
    cmp_tag0 = 3'(v.c0); cmp_tag1 = 3'(v.c1);
  endtask

  task automatic check_row(vec_t v);
    int st;
    st = ((v.v0 != 0) && !v.ei[0]) || ((v.v1 != 0) && !v.ei[1]);
    chk(v.rq, int'(issue), v.ei, "issue");
    chk(v.rq, int'(retire_cnt), v.er, "retire_cnt");
    chk(8, int'(fetch_stall), st, "fetch_stall");  // R8
    if (v.ei[0]) chk(1, int'(issue_tag0), exp_tail % 8, "issue_tag0");  // R1
    if (v.ei[1]) chk(1, int'(issue_tag1), (exp_tail + 1) % 8, "issue_tag1");
    exp_tail += int'(v.ei[0]) + int'(v.ei[1]);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R12 reset state
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(12, int'(issue), 0, "issue in reset");
    chk(12, int'(retire_cnt), 0, "retire_cnt in reset");
    chk(12, int'(fetch_stall), 0, "fetch_stall in reset");
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(TBL[i]);
      #1;
      check_row(TBL[i]);
    end

    // R12 reset mid-run with eight entries pending clears all reservations
    @(negedge clk);
    idle_inputs();
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk); #1;
    chk(12, int'(retire_cnt), 0, "retire_cnt after reset");
    chk(12, int'(issue), 0, "issue idle after reset");
    rst_n = 1'b1;
    exp_tail = 0;
    @(negedge clk);
    s0_valid = 1; s0_src_a = 1; s0_src_b = 0; s0_dst = 9; s0_unit = 0;
    s1_valid = 1; s1_src_a = 10; s1_src_b = 0; s1_dst = 3; s1_unit = 1;
    #1;
    chk(12, int'(issue), 3, "stale reservations gone");
    chk(12, int'(issue_tag0), 0, "first tag after reset");
    chk(12, int'(fetch_stall), 0, "no stall after reset");
    @(negedge clk);
    idle_inputs();
    cmp_valid = 2'b10; cmp_tag1 = 3'd1;  // R10 younger first
    @(negedge clk);
    cmp_valid = 2'b00;
    s0_valid = 1; s0_src_a = 3; s0_src_b = 3; s0_dst = 12; s0_unit = 2;
    #1;
    chk(10, int'(retire_cnt), 0, "younger done waits");
    chk(2, int'(issue), 0, "RAW on r3 held");  // R2
    @(negedge clk);
    cmp_valid = 2'b01; cmp_tag0 = 3'd0;
    #1;
    chk(2, int'(issue), 0, "RAW still held");
    @(negedge clk);
    cmp_valid = 2'b00;
    #1;
    chk(10, int'(retire_cnt), 2, "both retire in order");
    chk(11, int'(issue), 0, "not before release edge");
    @(negedge clk); #1;
    chk(11, int'(issue), 1, "issues after release");
    idle_inputs();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule